// File: doc/BRIEF.md
# SPI Master Data Queues with Threshold Interrupts

This block holds the data path buffering of an SPI master: a transmit queue that software fills and the shift engine drains, and a receive queue that the shift engine fills and software drains. Each queue is 16 entries deep and up to 32 bits wide. A width code in the configuration register sets how many low bytes of each entry are kept, so 8, 16, 24 and 32-bit words all fit one slot each.

Each direction has its own flag register, interrupt enable register and write-one-to-clear register, plus its own interrupt output. The full, empty and threshold flags follow the live fill count. A sticky slave-released flag latches a pulse from the shift engine and stays set until software clears it. Both fill counts can be read together from a status word. The configuration register holds one programmable threshold per direction and two self-clearing flush bits.

Software reaches the block through a simple single-cycle register port. The shift engine uses a pop/push strobe pair and a one-cycle release pulse.

Top module: `spi_data_fifo`

## Requirements
- R1: Each queue holds at most 16 entries. The status word (address 0x20) reports the receive fill count in bits 12:8 and the transmit fill count in bits 20:16, each as a value from 0 to 16.
- R2: Each queue returns entries in the order they were written. Transmit data is written at address 0x28 and appears on `eng_tx_data`. Receive data is pushed by the engine and read at address 0x2C, where each read strobe removes one entry.
- R3: A push to a full queue is ignored. The fill count stays at 16 and the stored entries are not changed.
- R4: A pop from an empty queue is ignored and returns zero.
- R5: The width code in configuration bits 9:8 (reset value 3) keeps only the low (code+1)*8 bits of every entry pushed into either queue. The remaining bits read as zero.
- R6: Transmit flags (address 0x00): bit 0 is full, bit 1 is empty, and bit 5 is set while the fill count is at or below the transmit threshold in configuration bits 7:4. All other bits read zero apart from bit 6.
- R7: Receive flags (address 0x10): bit 0 is full, bit 1 is empty, and bit 5 is set while the fill count is at or above the receive threshold in configuration bits 3:0.
- R8: Bit 6 of each flag register is set by an `eng_slave_rel` pulse and holds until a write with bit 6 set reaches that direction's clear register (transmit 0x08, receive 0x18). A pulse that arrives in the same cycle as the clear wins, and the bit stays set.
- R9: Clear-register writes have no effect on the full, empty and threshold flags. A clear write with bit 6 at zero leaves the released flag set.
- R10: Each interrupt output is high exactly when its flag register ANDed with its enable register (transmit 0x04, receive 0x14) is nonzero. Only bits 0, 1, 5 and 6 of an enable register are stored; the other bits read zero.
- R11: Writing configuration bit 11 empties the receive queue and writing bit 12 empties the transmit queue, both in the same cycle. The other fields of that write are stored, and both flush bits read back as zero.
- R12: After reset both queues are empty, the configuration reads 0x300, the enables and released flags are zero, both flag registers read 0x22, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive queue at 0x2C |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| eng_tx_pop | input | 1 | Shift engine takes the transmit head |
| eng_tx_data | output | 32 | Transmit head entry, zero when empty |
| eng_tx_avail | output | 1 | Transmit queue holds at least one entry |
| eng_rx_push | input | 1 | Shift engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_rx_space | output | 1 | Receive queue can accept a word |
| eng_slave_rel | input | 1 | One-cycle pulse: slave select released |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
A wrong pointer or fill counter shows up in the next register read. The status field then disagrees with the number of pushes and pops the bench counted, or a drained word disagrees with the arithmetic sequence that was written. The threshold, full and empty flags follow the count with no added latency, so a comparator error appears in the cycle right after the push that crosses the boundary. The bench sweeps every fill level from 0 to 16 against several thresholds. A sticky bit that drops or fails to clear shows in the first flag read after the release pulse or the clear write, and the interrupt pins show the same fault in that same cycle.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_TX_FLAG = 8'h00,
        A_TX_EN   = 8'h04,
        A_TX_CLR  = 8'h08,
        A_RX_FLAG = 8'h10,
        A_RX_EN   = 8'h14,
        A_RX_CLR  = 8'h18,
        A_STATUS  = 8'h20,
        A_CFG     = 8'h24,
        A_TX_DATA = 8'h28,
        A_RX_DATA = 8'h2C
    } reg_addr_e;

    // Flag bit positions shared by flag and enable registers
    localparam int FB_FULL  = 0;
    localparam int FB_EMPTY = 1;
    localparam int FB_THR   = 5;
    localparam int FB_REL   = 6;
    localparam logic [DATA_W-1:0] FLAG_MASK = 32'h0000_0063;

    // Status word field positions
    localparam int STAT_RX_LSB = 8;
    localparam int STAT_TX_LSB = 16;

    // Configuration flush bit positions
    localparam int CFG_FLUSH_RX = 11;
    localparam int CFG_FLUSH_TX = 12;

    typedef struct packed {
        logic [1:0] wcode;
        logic [3:0] tx_thr;
        logic [3:0] rx_thr;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{wcode: 2'd3, tx_thr: 4'd0, rx_thr: 4'd0};

    function automatic cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        cfg_t c;
        c.rx_thr = w[3:0];
        c.tx_thr = w[7:4];
        c.wcode  = w[9:8];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input cfg_t c);
        return {22'b0, c.wcode, c.tx_thr, c.rx_thr};
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] code);
        logic [DATA_W-1:0] m;
        m = '1;
        return m >> (8 * (3 - int'(code)));
    endfunction

endpackage

// File: rtl/sfq_queue.sv
module sfq_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          push,
    input  logic [W-1:0]                  push_data,
    input  logic                          pop,
    output logic [W-1:0]                  head_data,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          full,
    output logic                          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= push_data;
    end

    assign head_data = empty ? '0 : mem[rp];

    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    p_full_push_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);

    p_empty_pop_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

    p_flush_empties_r11: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/sfq_flags.sv
module sfq_flags
    import spi_fifo_pkg::*;
#(
    parameter bit IS_RX = 1'b0,
    parameter int CW    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     count,
    input  logic [3:0]        thr,
    input  logic              full,
    input  logic              empty,
    input  logic              rel_pulse,
    input  logic              en_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] flags,
    output logic [DATA_W-1:0] enables,
    output logic              irq
);
    logic rel_q;
    logic thr_hit;

    generate
        if (IS_RX) begin : g_rx_thr
            assign thr_hit = int'(count) >= int'(thr);
        end else begin : g_tx_thr
            assign thr_hit = int'(count) <= int'(thr);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            enables <= '0;
            rel_q   <= 1'b0;
        end else begin
            if (en_we) enables <= wdata & FLAG_MASK;
            if (rel_pulse)
                rel_q <= 1'b1;
            else if (clr_we && wdata[FB_REL])
                rel_q <= 1'b0;
        end
    end

    always_comb begin
        flags          = '0;
        flags[FB_FULL] = full;
        flags[FB_EMPTY]= empty;
        flags[FB_THR]  = thr_hit;
        flags[FB_REL]  = rel_q;
    end

    assign irq = |(flags & enables);

    p_rel_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (rel_q && !(clr_we && wdata[FB_REL])) |=> rel_q);

    p_rel_set_r8: assert property (@(posedge clk) disable iff (rst)
        rel_pulse |=> rel_q);

    p_en_mask_r10: assert property (@(posedge clk) disable iff (rst)
        (enables & ~FLAG_MASK) == '0);

    p_full_not_empty_r6: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

endmodule

// File: rtl/spi_data_fifo.sv
module spi_data_fifo
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_avail,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              eng_rx_space,
    input  logic              eng_slave_rel,
    output logic              irq_tx,
    output logic              irq_rx
);
    localparam int CW = $clog2(DEPTH+1);

    cfg_t              cfg_q;
    logic [DATA_W-1:0] mask;
    logic              cfg_we, flush_tx, flush_rx;
    logic              tx_push, rx_pop;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic [DATA_W-1:0] tx_flags, tx_en, rx_flags, rx_en;

    assign mask     = width_mask(cfg_q.wcode);
    assign cfg_we   = reg_wr && (reg_addr == A_CFG);
    assign flush_tx = cfg_we && reg_wdata[CFG_FLUSH_TX];
    assign flush_rx = cfg_we && reg_wdata[CFG_FLUSH_RX];
    assign tx_push  = reg_wr && (reg_addr == A_TX_DATA);
    assign rx_pop   = reg_rd && (reg_addr == A_RX_DATA);

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_RESET;
        else if (cfg_we) cfg_q <= word_to_cfg(reg_wdata);
    end

    sfq_queue #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_tx),
        .push      (tx_push),
        .push_data (reg_wdata & mask),
        .pop       (eng_tx_pop),
        .head_data (eng_tx_data),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    sfq_queue #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_rx),
        .push      (eng_rx_push),
        .push_data (eng_rx_data & mask),
        .pop       (rx_pop),
        .head_data (rx_head),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    sfq_flags #(.IS_RX(1'b0), .CW(CW)) u_txf (
        .clk       (clk),
        .rst       (rst),
        .count     (tx_cnt),
        .thr       (cfg_q.tx_thr),
        .full      (tx_full),
        .empty     (tx_empty),
        .rel_pulse (eng_slave_rel),
        .en_we     (reg_wr && (reg_addr == A_TX_EN)),
        .clr_we    (reg_wr && (reg_addr == A_TX_CLR)),
        .wdata     (reg_wdata),
        .flags     (tx_flags),
        .enables   (tx_en),
        .irq       (irq_tx)
    );

    sfq_flags #(.IS_RX(1'b1), .CW(CW)) u_rxf (
        .clk       (clk),
        .rst       (rst),
        .count     (rx_cnt),
        .thr       (cfg_q.rx_thr),
        .full      (rx_full),
        .empty     (rx_empty),
        .rel_pulse (eng_slave_rel),
        .en_we     (reg_wr && (reg_addr == A_RX_EN)),
        .clr_we    (reg_wr && (reg_addr == A_RX_CLR)),
        .wdata     (reg_wdata),
        .flags     (rx_flags),
        .enables   (rx_en),
        .irq       (irq_rx)
    );

    assign eng_tx_avail = !tx_empty;
    assign eng_rx_space = !rx_full;

    always_comb begin
        case (reg_addr)
            A_TX_FLAG: reg_rdata = tx_flags;
            A_TX_EN:   reg_rdata = tx_en;
            A_RX_FLAG: reg_rdata = rx_flags;
            A_RX_EN:   reg_rdata = rx_en;
            A_STATUS:  reg_rdata = (DATA_W'(rx_cnt) << STAT_RX_LSB)
                                 | (DATA_W'(tx_cnt) << STAT_TX_LSB);
            A_CFG:     reg_rdata = cfg_to_word(cfg_q);
            A_RX_DATA: reg_rdata = rx_head;
            default:   reg_rdata = '0;
        endcase
    end

    p_tx_data_width_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_push && !tx_full && tx_empty && !flush_tx && !eng_tx_pop)
        |=> ((eng_tx_data & ~$past(mask)) == '0));

    p_avail_tracks_r2: assert property (@(posedge clk) disable iff (rst)
        (!eng_tx_avail && !tx_push) |=> !eng_tx_avail);

endmodule

// File: tb/spi_data_fifo_tb.sv
module spi_data_fifo_tb;
    import spi_fifo_pkg::*;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        eng_tx_pop = 1'b0, eng_tx_avail;
    logic [31:0] eng_tx_data;
    logic        eng_rx_push = 1'b0, eng_rx_space;
    logic [31:0] eng_rx_data = '0;
    logic        eng_slave_rel = 1'b0;
    logic        irq_tx, irq_rx;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    spi_data_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_tx_avail(eng_tx_avail), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_rx_space(eng_rx_space),
        .eng_slave_rel(eng_slave_rel), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_tx(int cnt, int thr, bit rel);
        return 32'((cnt == DEPTH) ? 1 : 0) | 32'((cnt == 0) ? 2 : 0)
             | 32'((cnt <= thr) ? 32 : 0) | 32'(rel ? 64 : 0);
    endfunction

    function automatic logic [31:0] exp_rx(int cnt, int thr, bit rel);
        return 32'((cnt == DEPTH) ? 1 : 0) | 32'((cnt == 0) ? 2 : 0)
             | 32'((cnt >= thr) ? 32 : 0) | 32'(rel ? 64 : 0);
    endfunction

    function automatic logic [31:0] exp_stat(int rxc, int txc);
        return 32'(rxc) << 8 | 32'(txc) << 16;
    endfunction

    function automatic logic [31:0] cfgw(int rxt, int txt, int wc, bit frx, bit ftx);
        return 32'(rxt) | 32'(txt) << 4 | 32'(wc) << 8
             | (frx ? 32'h800 : 32'h0) | (ftx ? 32'h1000 : 32'h0);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rx_read(output logic [31:0] v);
        @(negedge clk);
        reg_addr = A_RX_DATA; reg_rd = 1'b1;
        #1;
        v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic eng_push(input logic [31:0] d);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic eng_pop(output logic [31:0] d);
        @(negedge clk);
        #1;
        d = eng_tx_data;
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic rel_pulse();
        @(negedge clk);
        eng_slave_rel = 1'b1;
        @(negedge clk);
        eng_slave_rel = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cnt;
        int thr_set [4] = '{0, 3, 8, 15};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        peek(A_STATUS, v);  chk("R12", "status", v, 32'h0);
        peek(A_CFG, v);     chk("R12", "cfg", v, 32'h300);
        peek(A_TX_FLAG, v); chk("R12", "tx flags", v, 32'h22);
        peek(A_RX_FLAG, v); chk("R12", "rx flags", v, 32'h22);
        peek(A_TX_EN, v);   chk("R12", "tx enable", v, 32'h0);
        chk("R12", "irqs", {30'b0, irq_tx, irq_rx}, 32'h0);

        // R1 R3 R6: transmit fill sweep with threshold 5
        wr(A_CFG, cfgw(0, 5, 3, 0, 0));
        for (int k = 0; k < 18; k++) begin
            wr(A_TX_DATA, 32'h1000_0000 + 32'(k) * 32'h0001_0203);
            cnt = (k + 1 > DEPTH) ? DEPTH : k + 1;
            peek(A_STATUS, v);  chk("R1_R3", "tx count", v, exp_stat(0, cnt));
            peek(A_TX_FLAG, v); chk("R6", "tx flags", v, exp_tx(cnt, 5, 1'b0));
        end
        // R2 R4: drain in order, then pop empty
        for (int k = 0; k < 18; k++) begin
            eng_pop(v);
            chk(k < DEPTH ? "R2" : "R4", "tx head", v,
                k < DEPTH ? 32'h1000_0000 + 32'(k) * 32'h0001_0203 : 32'h0);
        end
        peek(A_STATUS, v); chk("R4", "tx count after drain", v, exp_stat(0, 0));

        // R7 R3 R2 R4: receive fill sweep against several thresholds
        foreach (thr_set[i]) begin
            wr(A_CFG, cfgw(thr_set[i], 0, 3, 1, 0));
            for (int n = 0; n <= DEPTH; n++) begin
                peek(A_RX_FLAG, v);
                chk("R7", "rx flags", v, exp_rx(n, thr_set[i], 1'b0));
                if (n < DEPTH) eng_push(32'hC000_0000 + 32'(thr_set[i]) * 256 + 32'(n));
            end
            eng_push(32'hFFFF_FFFF);
            peek(A_STATUS, v); chk("R3", "rx count at full", v, exp_stat(DEPTH, 0));
            for (int n = 0; n < DEPTH; n++) begin
                rx_read(v);
                chk("R2", "rx order", v, 32'hC000_0000 + 32'(thr_set[i]) * 256 + 32'(n));
            end
            rx_read(v); chk("R4", "rx empty read", v, 32'h0);
        end

        // R5: width code masks both directions
        for (int c = 0; c < 4; c++) begin
            wr(A_CFG, cfgw(0, 0, c, 1, 1));
            wr(A_TX_DATA, 32'hDEAD_BEEF);
            eng_pop(v);
            chk("R5", "tx width", v, 32'hDEAD_BEEF & (32'hFFFF_FFFF >> (8 * (3 - c))));
            eng_push(32'h1234_5678);
            rx_read(v);
            chk("R5", "rx width", v, 32'h1234_5678 & (32'hFFFF_FFFF >> (8 * (3 - c))));
        end

        // R11: flush each queue independently
        wr(A_CFG, cfgw(0, 0, 3, 1, 1));
        for (int k = 0; k < 3; k++) wr(A_TX_DATA, 32'(k));
        eng_push(32'h5); eng_push(32'h6);
        peek(A_STATUS, v); chk("R11", "pre-flush", v, exp_stat(2, 3));
        wr(A_CFG, cfgw(2, 9, 3, 0, 1));
        peek(A_STATUS, v); chk("R11", "tx flushed", v, exp_stat(2, 0));
        peek(A_CFG, v);    chk("R11", "cfg readback", v, cfgw(2, 9, 3, 0, 0));
        wr(A_CFG, cfgw(2, 9, 3, 1, 0));
        peek(A_STATUS, v); chk("R11", "rx flushed", v, exp_stat(0, 0));
        peek(A_CFG, v);    chk("R11", "cfg readback 2", v, cfgw(2, 9, 3, 0, 0));

        // R8 R9: sticky release flag
        rel_pulse();
        peek(A_TX_FLAG, v); chk("R8", "tx rel set", v, exp_tx(0, 9, 1'b1));
        peek(A_RX_FLAG, v); chk("R8", "rx rel set", v, exp_rx(0, 2, 1'b1));
        wr(A_TX_CLR, 32'hFFFF_FFBF);
        peek(A_TX_FLAG, v); chk("R9", "clear without bit6", v, exp_tx(0, 9, 1'b1));
        wr(A_TX_CLR, 32'h40);
        peek(A_TX_FLAG, v); chk("R8", "tx rel cleared", v, exp_tx(0, 9, 1'b0));
        peek(A_RX_FLAG, v); chk("R8", "rx rel kept", v, exp_rx(0, 2, 1'b1));
        wr(A_RX_CLR, 32'hFFFF_FFFF);
        peek(A_RX_FLAG, v); chk("R9", "rx levels after clear", v, exp_rx(0, 2, 1'b0));
        @(negedge clk);
        eng_slave_rel = 1'b1; reg_wr = 1'b1; reg_addr = A_TX_CLR; reg_wdata = '1;
        @(negedge clk);
        eng_slave_rel = 1'b0; reg_wr = 1'b0;
        peek(A_TX_FLAG, v); chk("R8", "set beats clear", v, exp_tx(0, 9, 1'b1));
        wr(A_TX_CLR, '1); wr(A_RX_CLR, '1);

        // R10: enables and interrupt outputs
        wr(A_TX_EN, 32'hFFFF_FFFF);
        peek(A_TX_EN, v); chk("R10", "tx enable mask", v, 32'h63);
        chk("R10", "irq_tx empty", {31'b0, irq_tx}, 32'h1);
        wr(A_TX_EN, 32'h1);
        chk("R10", "irq_tx off", {31'b0, irq_tx}, 32'h0);
        for (int k = 0; k < DEPTH; k++) wr(A_TX_DATA, 32'(k));
        chk("R10", "irq_tx full", {31'b0, irq_tx}, 32'h1);
        wr(A_CFG, cfgw(2, 9, 3, 0, 1));
        chk("R10", "irq_tx after flush", {31'b0, irq_tx}, 32'h0);
        wr(A_RX_EN, 32'h40);
        chk("R10", "irq_rx idle", {31'b0, irq_rx}, 32'h0);
        rel_pulse();
        chk("R10", "irq_rx rel", {31'b0, irq_rx}, 32'h1);
        chk("R10", "irq_tx masked rel", {31'b0, irq_tx}, 32'h0);
        wr(A_RX_CLR, 32'h40);
        chk("R10", "irq_rx cleared", {31'b0, irq_rx}, 32'h0);
        wr(A_RX_EN, 32'h20);
        eng_push(32'h1);
        chk("R10", "irq_rx below thr", {31'b0, irq_rx}, 32'h0);
        eng_push(32'h2);
        chk("R10", "irq_rx at thr", {31'b0, irq_rx}, 32'h1);

        summary();
        $finish;
    end

endmodule